// File: doc/BRIEF.md
# Batch Job Sequencer for RAM-Fed Compute

This block is a clocked controller that works through a fixed batch of two-operand jobs stored in a single-port synchronous RAM. For each job it fetches a first operand and a second operand from two separate address regions. It hands both to an external compute unit through a start/done handshake. When the unit finishes, it stores the result in a third region. It then steps all three region pointers and begins the next job. When the batch is complete, it parks, raising a completion flag and an interrupt.

The states, with their visible codes, are: `ST_RESET` (1, post-reset), `ST_RAMWAIT` (2, wait for the memory to be ready), `ST_LOADA` (3, present the first-operand address), `ST_LOADB` (4, capture the first operand and present the second-operand address), `ST_KICK` (5, capture the second operand and arm the start line), `ST_WAIT` (6, wait for done), `ST_WRITE` (7, write strobe active), `ST_ADVANCE` (8, step the pointers or end the batch) and `ST_PARKED` (9, absorbing).

The transitions are:
- `ST_RESET` always goes to `ST_RAMWAIT`.
- `ST_RAMWAIT` goes to `ST_LOADA` once the memory reports ready.
- `ST_LOADA` goes to `ST_LOADB`, then to `ST_KICK`, then to `ST_WAIT`.
- `ST_WAIT` goes to `ST_WRITE` when done is seen.
- `ST_WRITE` goes to `ST_ADVANCE`.
- `ST_ADVANCE` goes to `ST_PARKED` when the first-operand pointer is at its last value, and otherwise back to `ST_LOADA`.

Top module: `jobseq_top`

## Requirements
- R1: While `rst` (synchronous, active high) is high at a clock edge, the block enters state code 1, with `ram_we`, `cu_start`, `batch_done` and `irq` low. All three pointers return to their bases.
- R2: From code 1 the block moves to code 2. It stays in code 2, with `ram_we` low, for as long as `ram_ready` is low, and moves to code 3 on the edge where it is sampled high.
- R3: Each job passes through codes 3, 4, 5, 6 (held until done), 7 and 8 in that order, and `state_code` reports the current code.
- R4: In code 3, `ram_addr` is the first-operand pointer (base 0). In code 4 it is the second-operand pointer (base 50). In code 7 it is the result pointer (base 110). All three are 10-bit addresses.
- R5: The RAM returns data one cycle after the address is presented. While `cu_start` is high, `cu_op_a` and `cu_op_b` equal the RAM words at the current job's first- and second-operand addresses.
- R6: `cu_start` rises on leaving code 5 and stays high until the edge where `cu_done` is sampled high in code 6. On that same edge `cu_start` falls and `ram_we` rises. `ram_wdata` then carries the `cu_result` value sampled at that edge.
- R7: `ram_we` is high for exactly one cycle per job, in code 7, and is low again in code 8.
- R8: At code 8 all three pointers step by one, unless the first-operand pointer equals 7. In that case the block goes to code 9, so a batch makes exactly 8 writes, to addresses 110 to 117.
- R9: Code 9 is absorbing until reset. In it, `batch_done` and `irq` are high and `ram_we` and `cu_start` stay low. Both flags are low in every other state.
- R10: A reset in the middle of a batch restarts the next batch at first-operand address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_ready | input | 1 | Memory ready to serve reads |
| ram_addr | output | 10 | RAM address |
| ram_rdata | input | 16 | RAM read data, one cycle after address |
| ram_wdata | output | 16 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| cu_start | output | 1 | Start request to compute unit |
| cu_op_a | output | 16 | First operand |
| cu_op_b | output | 16 | Second operand |
| cu_done | input | 1 | Compute unit finished |
| cu_result | input | 16 | Compute unit result |
| batch_done | output | 1 | Batch complete status |
| irq | output | 1 | Completion interrupt |
| state_code | output | 4 | Current state code (1 to 9) |

## Verification
A wrong state shows on `state_code` in the same cycle. It shows one cycle later as a misplaced address in the load or write state. A corrupt pointer shows as a wrong `ram_addr` at the next load of the following job. A slip in the read-latency alignment appears as wrong operands on `cu_op_a`/`cu_op_b` as soon as `cu_start` rises. A wrong end condition shows as a write count other than eight, or as flags that rise early or fall again while parked.

// File: rtl/jobseq_pkg.sv
package jobseq_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd1,
        ST_RAMWAIT = 4'd2,
        ST_LOADA   = 4'd3,
        ST_LOADB   = 4'd4,
        ST_KICK    = 4'd5,
        ST_WAIT    = 4'd6,
        ST_WRITE   = 4'd7,
        ST_ADVANCE = 4'd8,
        ST_PARKED  = 4'd9
    } seq_state_t;

endpackage

// File: rtl/jobseq_ptr.sv
module jobseq_ptr #(
    parameter int ADDR_W = 10,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] value
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

    always_ff @(posedge clk) begin
        if (rst)
            value <= BASE_V;
        else if (step)
            value <= value + 1'b1;
    end
endmodule

// File: rtl/jobseq_fsm.sv
module jobseq_fsm
    import jobseq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LAST_A = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ram_ready,
    input  logic              cu_done,
    input  logic [ADDR_W-1:0] ptr_a,
    input  logic [ADDR_W-1:0] ptr_b,
    input  logic [ADDR_W-1:0] ptr_r,
    output seq_state_t        state,
    output logic              step,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              batch_done,
    output logic              irq,
    output logic [3:0]        state_code
);
    localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(LAST_A);

    seq_state_t next_state;
    logic       at_last;

    assign at_last = (ptr_a == LAST_V);

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_RESET;
        else
            state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_RESET:   next_state = ST_RAMWAIT;
            ST_RAMWAIT: next_state = ram_ready ? ST_LOADA : ST_RAMWAIT;
            ST_LOADA:   next_state = ST_LOADB;
            ST_LOADB:   next_state = ST_KICK;
            ST_KICK:    next_state = ST_WAIT;
            ST_WAIT:    next_state = cu_done ? ST_WRITE : ST_WAIT;
            ST_WRITE:   next_state = ST_ADVANCE;
            ST_ADVANCE: next_state = at_last ? ST_PARKED : ST_LOADA;
            ST_PARKED:  next_state = ST_PARKED;
            default:    next_state = ST_RESET;
        endcase
    end

    always_comb begin
        step       = 1'b0;
        ram_addr   = ptr_a;
        batch_done = 1'b0;
        irq        = 1'b0;
        state_code = state;
        unique case (state)
            ST_LOADA:   ram_addr = ptr_a;
            ST_LOADB:   ram_addr = ptr_b;
            ST_KICK:    ram_addr = ptr_b;
            ST_WAIT:    ram_addr = ptr_r;
            ST_WRITE:   ram_addr = ptr_r;
            ST_ADVANCE: step = !at_last;
            ST_PARKED: begin
                batch_done = 1'b1;
                irq        = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/jobseq_datapath.sv
module jobseq_datapath
    import jobseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_t        state,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              cu_done,
    input  logic [DATA_W-1:0] cu_result,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic              start,
    output logic              we,
    output logic [DATA_W-1:0] wdata
);
    logic finish_seen;

    assign finish_seen = (state == ST_WAIT) && cu_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a  <= '0;
            op_b  <= '0;
            start <= 1'b0;
            we    <= 1'b0;
            wdata <= '0;
        end else begin
            if (state == ST_LOADB)
                op_a <= ram_rdata;
            if (state == ST_KICK)
                op_b <= ram_rdata;
            if (state == ST_KICK)
                start <= 1'b1;
            else if (finish_seen)
                start <= 1'b0;
            we <= finish_seen;
            if (finish_seen)
                wdata <= cu_result;
        end
    end
endmodule

// File: rtl/jobseq_top.sv
module jobseq_top
    import jobseq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int BASE_A = 0,
    parameter int BASE_B = 50,
    parameter int BASE_R = 110,
    parameter int LAST_A = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ram_ready,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              cu_start,
    output logic [DATA_W-1:0] cu_op_a,
    output logic [DATA_W-1:0] cu_op_b,
    input  logic              cu_done,
    input  logic [DATA_W-1:0] cu_result,
    output logic              batch_done,
    output logic              irq,
    output logic [3:0]        state_code
);
    localparam int NPTR = 3;
    localparam int BASES [NPTR] = '{BASE_A, BASE_B, BASE_R};

    seq_state_t        state;
    logic              step;
    logic [ADDR_W-1:0] ptrs [NPTR];

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        jobseq_ptr #(.ADDR_W(ADDR_W), .BASE(BASES[g])) u_ptr (
            .clk   (clk),
            .rst   (rst),
            .step  (step),
            .value (ptrs[g])
        );
    end

    jobseq_fsm #(.ADDR_W(ADDR_W), .LAST_A(LAST_A)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ram_ready  (ram_ready),
        .cu_done    (cu_done),
        .ptr_a      (ptrs[0]),
        .ptr_b      (ptrs[1]),
        .ptr_r      (ptrs[2]),
        .state      (state),
        .step       (step),
        .ram_addr   (ram_addr),
        .batch_done (batch_done),
        .irq        (irq),
        .state_code (state_code)
    );

    jobseq_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ram_rdata (ram_rdata),
        .cu_done   (cu_done),
        .cu_result (cu_result),
        .op_a      (cu_op_a),
        .op_b      (cu_op_b),
        .start     (cu_start),
        .we        (ram_we),
        .wdata     (ram_wdata)
    );
endmodule

// File: rtl/jobseq_chk.sv
module jobseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ram_ready,
    input logic       ram_we,
    input logic       cu_start,
    input logic       cu_done,
    input logic       batch_done,
    input logic       irq,
    input logic [3:0] state_code
);
    // R7
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);

    // R7
    we_state_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> state_code == 4'd7);

    // R6
    start_hand_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cu_start) |-> ram_we);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !cu_start);

    // R9
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        batch_done |=> batch_done && state_code == 4'd9);

    // R9
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        batch_done == irq);

    // R2
    wait_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd2 && !ram_ready) |=> state_code == 4'd2 && !ram_we);
endmodule

bind jobseq_top jobseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ram_ready  (ram_ready),
    .ram_we     (ram_we),
    .cu_start   (cu_start),
    .cu_done    (cu_done),
    .batch_done (batch_done),
    .irq        (irq),
    .state_code (state_code)
);

// File: tb/jobseq_top_test.sv
`timescale 1ns/1ps
module jobseq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ram_ready = 1'b0;
    logic [9:0]  ram_addr;
    logic [15:0] ram_rdata;
    logic [15:0] ram_wdata;
    logic        ram_we;
    logic        cu_start;
    logic [15:0] cu_op_a, cu_op_b;
    logic        cu_done;
    logic [15:0] cu_result;
    logic        batch_done, irq;
    logic [3:0]  state_code;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    logic [15:0] mem [1024];
    int          jobs_served;
    int          wait_cnt;

    always #2.5 clk = ~clk;

    jobseq_top uut (
        .clk(clk), .rst(rst), .ram_ready(ram_ready), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .cu_start(cu_start), .cu_op_a(cu_op_a), .cu_op_b(cu_op_b),
        .cu_done(cu_done), .cu_result(cu_result), .batch_done(batch_done),
        .irq(irq), .state_code(state_code)
    );

    function automatic logic [15:0] init_word(int i);
        return 16'(i * 13 + 5);
    endfunction

    function automatic logic [15:0] job_fn(logic [15:0] a, logic [15:0] b);
        return 16'(a * 2 + b);
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = init_word(i);
    end

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= mem[ram_addr];
    end

    // compute unit model: latency varies per job
    always @(posedge clk) begin
        if (rst) begin
            cu_done <= 1'b0; cu_result <= '0; wait_cnt <= 0; jobs_served <= 0;
        end else if (cu_done) begin
            cu_done <= 1'b0; wait_cnt <= 0;
        end else if (cu_start) begin
            if (wait_cnt == jobs_served % 4) begin
                cu_done     <= 1'b1;
                cu_result   <= job_fn(cu_op_a, cu_op_b);
                jobs_served <= jobs_served + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            summary();
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(state_code == 4'd1, "R1 state code", state_code, 1);
        chk(!ram_we && !cu_start, "R1 we/start low", {ram_we, cu_start}, 0);
        chk(!batch_done && !irq, "R1 flags low", {batch_done, irq}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(state_code == 4'd2, "R2 enter ram wait", state_code, 2);
    endtask

    task automatic t_ram_wait();
        bit ok = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (state_code != 4'd2 || ram_we) ok = 0;
        end
        chk(ok, "R2 hold while not ready", state_code, 2);
        ram_ready = 1'b1;
        @(negedge clk);
        chk(state_code == 4'd3, "R2 leave on ready", state_code, 3);
        chk(ram_addr == 10'd0, "R4 first A address", ram_addr, 0);
    endtask

    task automatic t_batch();
        int  k = 0;
        int  n = 0;
        int  prev = -1;
        bit  ops_done = 0;
        bit  order_ok = 1;
        while (state_code != 4'd9 && n < 2000) begin
            if (prev != -1 && state_code != prev[3:0]) begin
                case (prev)
                    3: if (state_code != 4) order_ok = 0;
                    4: if (state_code != 5) order_ok = 0;
                    5: if (state_code != 6) order_ok = 0;
                    6: if (state_code != 7) order_ok = 0;
                    7: if (state_code != 8) order_ok = 0;
                    8: if (state_code != 3 && state_code != 9) order_ok = 0;
                    default: ;
                endcase
            end
            if (state_code == 4'd3)
                chk(ram_addr == 10'(k), "R4 A address", ram_addr, k);
            if (state_code == 4'd4)
                chk(ram_addr == 10'(50 + k), "R4 B address", ram_addr, 50 + k);
            if (cu_start && !ops_done) begin
                ops_done = 1;
                chk(cu_op_a == init_word(k), "R5 operand A", cu_op_a, init_word(k));
                chk(cu_op_b == init_word(50 + k), "R5 operand B", cu_op_b, init_word(50 + k));
            end
            if (ram_we) begin
                chk(ram_addr == 10'(110 + k), "R4 result address", ram_addr, 110 + k);
                chk(ram_wdata == job_fn(init_word(k), init_word(50 + k)), "R6 write data",
                    ram_wdata, job_fn(init_word(k), init_word(50 + k)));
                chk(!cu_start && state_code == 4'd7, "R7 write cycle", state_code, 7);
                k++;
                ops_done = 0;
            end
            if (state_code == 4'd8)
                chk(!ram_we, "R7 we low after write", ram_we, 0);
            prev = state_code;
            n++;
            @(negedge clk);
        end
        chk(order_ok, "R3 state order", prev, 8);
        chk(k == 8, "R8 write count", k, 8);
        chk(state_code == 4'd9, "R8 parked", state_code, 9);
    endtask

    task automatic t_park();
        bit ok = 1;
        for (int i = 0; i < 30; i++) begin
            if (!batch_done || !irq || ram_we || cu_start || state_code != 4'd9) ok = 0;
            @(negedge clk);
        end
        chk(ok, "R9 absorbing park", state_code, 9);
    endtask

    task automatic t_midreset();
        int n = 0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!batch_done && !irq && state_code == 4'd1, "R1 reset clears park", state_code, 1);
        rst = 1'b0;
        while (!(state_code == 4'd3 && ram_addr == 10'd3) && n < 2000) begin
            @(negedge clk); n++;
        end
        chk(ram_addr == 10'd3, "R10 reached job 3", ram_addr, 3);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (state_code != 4'd3 && n < 100) begin
            @(negedge clk); n++;
        end
        chk(ram_addr == 10'd0, "R10 restart at A base", ram_addr, 0);
        t_batch();
    endtask

    initial begin
        t_reset();
        t_ram_wait();
        t_batch();
        t_park();
        t_midreset();
        t_park();
        summary();
    end
endmodule